// File: doc/BRIEF.md
# Selectable-Polynomial PRBS Source and Self-Synchronizing Checker

This block drives pseudo-random test words onto a parallel datapath and checks such words on the receive side. Four polynomials can be picked at run time through a two-bit select. The transmit half is a linear feedback shift register. It is unrolled so that one whole word of consecutive sequence bits comes out on every enabled clock. It starts from a seed that software or a test controller loads through a load strobe.

The receive half holds no seed of its own. It predicts each incoming bit from the bits it has already received, the same way a self-synchronizing descrambler works. It starts building its history only once an external alignment input reports that the link is aligned. After a fixed number of octets has arrived, it declares lock and starts comparing. Each compared word that holds a wrong bit raises a saturating error counter and a sticky flag. A change of polynomial, or loss of alignment, throws lock away and restarts synchronization.

Top module: `prbs_gen_chk`

## Requirements
- R1: `poly_sel` picks the recurrence b[n] = b[n-L] ^ b[n-T] with encoding 0: L=7,T=6; 1: L=9,T=5; 2: L=15,T=14; 3: L=23,T=18. Both halves use the select that is live in the current cycle.
- R2: In each cycle with `gen_en` high and `gen_load` low, the generator emits the next DATA_W sequence bits. The earliest bit is on `gen_data[DATA_W-1]`. The word is visible, with `gen_valid` high, after that clock edge. A cycle without `gen_en` sets `gen_valid` low and leaves the sequence position unchanged.
- R3: A `gen_load` cycle sets `gen_valid` low, even if `gen_en` is high in the same cycle. After it, the first emitted bit is b[0], where b[-1-k] equals `gen_seed[k]` for k < L.
- R4: If the seed bits below L are all zero, the generator uses all ones in those L bits instead.
- R5: Valid words that arrive while `align_ok` is low add nothing toward lock, and `locked` stays low.
- R6: `locked` goes high on the edge that ends the valid, aligned word which brings the received total to SYNC_OCTETS octets. Cycles with `rx_valid` low count nothing.
- R7: While locked, every valid word that holds at least one bit differing from b[n-L] ^ b[n-T], computed over the received bits, adds exactly one to `err_cnt`. A single flipped bit at stream position p therefore disturbs positions p, p+T and p+L.
- R8: `err_cnt` (CNT_W bits) stops at all ones and does not wrap.
- R9: `err_flag` sets on the first counted error word and stays set. An `err_clr` cycle zeroes both the count and the flag. If an error word falls in that same cycle, the result is a count of 1 with the flag set.
- R10: A change of `poly_sel`, or a cycle with `align_ok` low, clears `locked` on the next edge and restarts the octet total from zero. A word in that cycle is never counted as an error.
- R11: After reset, `locked`, `err_flag`, `err_cnt`, `gen_valid` and `gen_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poly_sel | input | 2 | Polynomial select (R1 encoding) |
| gen_en | input | 1 | Advance generator by one word |
| gen_load | input | 1 | Load generator seed |
| gen_seed | input | 23 | Generator seed |
| gen_data | output | DATA_W | Generated word, earliest bit in MSB |
| gen_valid | output | 1 | `gen_data` holds a new word |
| align_ok | input | 1 | Link alignment achieved |
| rx_valid | input | 1 | `rx_data` holds a word |
| rx_data | input | DATA_W | Received word, earliest bit in MSB |
| err_clr | input | 1 | Clear error count and flag |
| err_cnt | output | CNT_W | Saturating count of errored words |
| err_flag | output | 1 | Sticky error indication |
| locked | output | 1 | Checker synchronized and comparing |

## Verification
Two events can land on the same edge. One is a clear together with an errored word. The other is a restart, caused by a polynomial change or lost alignment, together with a word that would mismatch. The bench forces both. It drives `err_clr` on the very word whose flipped bit it placed there, and expects a count of exactly 1 with the flag set. It also switches `poly_sel` on a deliberately inverted word, and expects lock to drop while the count does not move. The expected number of errored words after each flip comes from arithmetic on the positions p, p+T and p+L, set against the word boundaries.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int HIST_W = 23;

  typedef enum logic [1:0] {
    POLY_7  = 2'd0,
    POLY_9  = 2'd1,
    POLY_15 = 2'd2,
    POLY_23 = 2'd3
  } poly_e;

  // Low L bits set: the part of the history a polynomial actually uses.
  function automatic logic [HIST_W-1:0] poly_mask(poly_e p);
    case (p)
      POLY_7:  return 23'h00007F;
      POLY_9:  return 23'h0001FF;
      POLY_15: return 23'h007FFF;
      default: return 23'h7FFFFF;
    endcase
  endfunction

  // h[k] holds b[n-1-k]; result is b[n] = b[n-L] ^ b[n-T].
  function automatic logic fb_bit(logic [HIST_W-1:0] h, poly_e p);
    case (p)
      POLY_7:  return h[6]  ^ h[5];
      POLY_9:  return h[8]  ^ h[4];
      POLY_15: return h[14] ^ h[13];
      default: return h[22] ^ h[17];
    endcase
  endfunction
endpackage

// File: rtl/prbs_word_step.sv
module prbs_word_step
  import prbs_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  poly_e              sel,
  input  logic [HIST_W-1:0]  hist_in,
  input  logic [DATA_W-1:0]  rx_bits,
  input  logic               use_rx,
  output logic [DATA_W-1:0]  pred,
  output logic [HIST_W-1:0]  hist_out
);
  // One stage per bit, earliest bit at the MSB. In receive mode the
  // history is refilled from the received bits (self-synchronizing).
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam int POS = DATA_W - 1 - i;
    logic [HIST_W-1:0] h_cur;
    logic [HIST_W-1:0] h_nxt;
    logic              nb;
    if (i == 0) begin : g_first
      assign h_cur = hist_in;
    end else begin : g_rest
      assign h_cur = g_bit[i-1].h_nxt;
    end
    assign pred[POS] = fb_bit(h_cur, sel);
    assign nb        = use_rx ? rx_bits[POS] : pred[POS];
    assign h_nxt     = {h_cur[HIST_W-2:0], nb};
  end
  assign hist_out = g_bit[DATA_W-1].h_nxt;
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  poly_e              sel,
  input  logic               en,
  input  logic               load,
  input  logic [HIST_W-1:0]  seed,
  output logic [DATA_W-1:0]  data,
  output logic               valid
);
  logic [HIST_W-1:0] state_q, state_nxt, seed_m, seed_eff;
  logic [DATA_W-1:0] word;
  logic              seed_zero;

  prbs_word_step #(.DATA_W(DATA_W)) u_step (
    .sel      (sel),
    .hist_in  (state_q),
    .rx_bits  ('0),
    .use_rx   (1'b0),
    .pred     (word),
    .hist_out (state_nxt)
  );

  assign seed_m    = seed & poly_mask(sel);
  assign seed_zero = (seed_m == '0);
  assign seed_eff  = seed_zero ? poly_mask(sel) : seed_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '1;
      data    <= '0;
      valid   <= 1'b0;
    end else if (load) begin
      state_q <= seed_eff;
      valid   <= 1'b0;
    end else if (en) begin
      state_q <= state_nxt;
      data    <= word;
      valid   <= 1'b1;
    end else begin
      valid   <= 1'b0;
    end
  end

  p_seed_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state_q != '0);
  p_load_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> ($stable(state_q) && !valid));
endmodule

// File: rtl/prbs_lock_ctl.sv
module prbs_lock_ctl
  import prbs_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int SYNC_OCTETS = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  poly_e sel,
  input  logic  align_ok,
  input  logic  rx_valid,
  output logic  restart,
  output logic  locked
);
  localparam int OCT_PER_WORD = DATA_W / 8;
  localparam int OCT_W        = $clog2(SYNC_OCTETS + OCT_PER_WORD + 1);

  poly_e            sel_q;
  logic [OCT_W-1:0] oct_q, oct_nxt;
  logic             sync_done;

  assign restart   = !align_ok || (sel != sel_q);
  assign oct_nxt   = oct_q + OCT_W'(OCT_PER_WORD);
  assign sync_done = (oct_nxt >= OCT_W'(SYNC_OCTETS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= POLY_7;
      oct_q  <= '0;
      locked <= 1'b0;
    end else begin
      sel_q <= sel;
      if (restart) begin
        oct_q  <= '0;
        locked <= 1'b0;
      end else if (rx_valid && !locked) begin
        oct_q <= oct_nxt;
        if (sync_done) locked <= 1'b1;
      end
    end
  end

  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !locked);
  p_lock_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(rx_valid && align_ok));
  p_no_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !align_ok |=> (oct_q == '0));
endmodule

// File: rtl/prbs_err_acc.sv
module prbs_err_acc #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  logic at_max;

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  assign at_max = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (clr) begin
      cnt  <= hit ? CNT_W'(1) : '0;
      flag <= hit;
    end else if (hit) begin
      cnt  <= sat_inc(cnt);
      flag <= 1'b1;
    end
  end

  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !clr) |=> (&cnt));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt <= CNT_W'(1)));
  p_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/prbs_gen_chk.sv
module prbs_gen_chk
  import prbs_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int CNT_W       = 32,
  parameter int SYNC_OCTETS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        poly_sel,
  input  logic              gen_en,
  input  logic              gen_load,
  input  logic [22:0]       gen_seed,
  output logic [DATA_W-1:0] gen_data,
  output logic              gen_valid,
  input  logic              align_ok,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              err_clr,
  output logic [CNT_W-1:0]  err_cnt,
  output logic              err_flag,
  output logic              locked
);
  poly_e             sel;
  logic [HIST_W-1:0] hist_q, hist_nxt;
  logic [DATA_W-1:0] pred, mismatch;
  logic              restart, word_bad, err_hit;

  assign sel = poly_e'(poly_sel);

  prbs_gen #(.DATA_W(DATA_W)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .en    (gen_en),
    .load  (gen_load),
    .seed  (gen_seed),
    .data  (gen_data),
    .valid (gen_valid)
  );

  prbs_word_step #(.DATA_W(DATA_W)) u_rx_step (
    .sel      (sel),
    .hist_in  (hist_q),
    .rx_bits  (rx_data),
    .use_rx   (1'b1),
    .pred     (pred),
    .hist_out (hist_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (rx_valid) hist_q <= hist_nxt;
  end

  prbs_lock_ctl #(.DATA_W(DATA_W), .SYNC_OCTETS(SYNC_OCTETS)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .align_ok (align_ok),
    .rx_valid (rx_valid),
    .restart  (restart),
    .locked   (locked)
  );

  assign mismatch = pred ^ rx_data;
  assign word_bad = |mismatch;
  assign err_hit  = rx_valid && locked && !restart && word_bad;

  prbs_err_acc #(.CNT_W(CNT_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (err_hit),
    .clr   (err_clr),
    .cnt   (err_cnt),
    .flag  (err_flag)
  );

  p_quiet_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !err_clr) |=> $stable(err_cnt));
  p_valid_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !err_clr) |=> $stable(err_cnt));
  p_restart_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !err_clr) |=> $stable(err_cnt));
endmodule

// File: tb/prbs_gen_chk_tb_top.sv
`timescale 1ns/1ps
module prbs_gen_chk_tb_top;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int SO = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    poly_sel = 2'd0;
  logic          gen_en = 1'b0, gen_load = 1'b0;
  logic [22:0]   gen_seed = '0;
  logic [DW-1:0] gen_data;
  logic          gen_valid;
  logic          align_ok = 1'b0, rx_valid = 1'b0, err_clr = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [CW-1:0] err_cnt;
  logic          err_flag, locked;

  int  checks = 0;
  int  errs = 0;
  bit  done = 0;
  bit  s [0:1046];
  int  lens [4] = '{7, 9, 15, 23};
  int  taps [4] = '{6, 5, 14, 18};

  always #2 clk = ~clk;

  prbs_gen_chk #(.DATA_W(DW), .CNT_W(CW), .SYNC_OCTETS(SO)) dut_i (
    .clk, .rst_n, .poly_sel, .gen_en, .gen_load, .gen_seed, .gen_data,
    .gen_valid, .align_ok, .rx_valid, .rx_data, .err_clr, .err_cnt,
    .err_flag, .locked
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Sequence model: s[22-k] = b[-1-k], s[23+n] = b[n].
  task automatic build_seq(input int sel, input logic [22:0] seed);
    longint m;
    logic [22:0] sd;
    m  = (64'd1 << lens[sel]) - 1;
    sd = seed & m[22:0];
    if (sd == '0) sd = m[22:0];
    for (int k = 0; k < 23; k++) s[22-k] = sd[k];
    for (int n = 0; n < 1000; n++)
      s[n+23] = s[n+23-lens[sel]] ^ s[n+23-taps[sel]];
  endtask

  function automatic logic [DW-1:0] word_of(input int w);
    logic [DW-1:0] r;
    for (int j = 0; j < DW; j++) r[DW-1-j] = s[23 + w*DW + j];
    return r;
  endfunction

  // Words disturbed by one flipped bit at position p.
  function automatic int hit_words(input int sel, input int p);
    int w0, w1, w2, n;
    w0 = p / DW; w1 = (p + taps[sel]) / DW; w2 = (p + lens[sel]) / DW;
    n = 1;
    if (w1 != w0) n++;
    if (w2 != w0 && w2 != w1) n++;
    return n;
  endfunction

  task automatic gen_cyc(input logic en, input logic ld);
    @(negedge clk); gen_en = en; gen_load = ld;
    @(posedge clk); #1; gen_en = 1'b0; gen_load = 1'b0;
  endtask

  task automatic rx_cyc(input logic v, input logic [DW-1:0] d, input logic al, input logic clr);
    @(negedge clk); rx_valid = v; rx_data = d; align_ok = al; err_clr = clr;
    @(posedge clk); #1; rx_valid = 1'b0; err_clr = 1'b0;
  endtask

  task automatic lock_up(input int first);
    for (int w = first; w < first + 4; w++) rx_cyc(1'b1, word_of(w), 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R11 locked", 32'(locked), 0);
    chk("R11 err_cnt", 32'(err_cnt), 0);
    chk("R11 err_flag", 32'(err_flag), 0);
    chk("R11 gen_valid", 32'(gen_valid), 0);
    chk("R11 gen_data", 32'(gen_data), 0);

    // Generator sweep over all polynomials (R1, R2, R3)
    for (int sl = 0; sl < 4; sl++) begin
      logic [22:0] seed;
      seed = 23'h4C3A1 + 23'(sl) * 23'h1111;
      poly_sel = 2'(sl);
      gen_seed = seed;
      build_seq(sl, seed);
      gen_cyc(sl == 2, 1'b1);
      chk("R3 load gives no word", 32'(gen_valid), 0);
      for (int w = 0; w < 40; w++) begin
        if (w == 10) begin
          gen_cyc(1'b0, 1'b0);
          chk("R2 idle valid low", 32'(gen_valid), 0);
          gen_cyc(1'b0, 1'b0);
        end
        gen_cyc(1'b1, 1'b0);
        chk("R2 valid", 32'(gen_valid), 1);
        chk("R1 R2 word", 32'(gen_data), 32'(word_of(w)));
      end
    end

    // Zero seed replacement (R4)
    poly_sel = 2'd3; gen_seed = 23'h0; build_seq(3, 23'h0);
    gen_cyc(1'b0, 1'b1);
    for (int w = 0; w < 8; w++) begin
      gen_cyc(1'b1, 1'b0);
      chk("R4 zero seed p23", 32'(gen_data), 32'(word_of(w)));
    end
    poly_sel = 2'd1; gen_seed = 23'h7FFE00; build_seq(1, 23'h7FFE00);
    gen_cyc(1'b0, 1'b1);
    for (int w = 0; w < 8; w++) begin
      gen_cyc(1'b1, 1'b0);
      chk("R4 masked zero seed p9", 32'(gen_data), 32'(word_of(w)));
    end

    // Checker per polynomial (R5, R6, R7, R9, R10)
    for (int sl = 0; sl < 4; sl++) begin
      int exp_n;
      logic [DW-1:0] d;
      poly_sel = 2'(sl);
      build_seq(sl, 23'h1234 + 23'(sl));
      rx_cyc(1'b0, '0, 1'b0, 1'b1);
      chk("R9 clear count", 32'(err_cnt), 0);
      chk("R9 clear flag", 32'(err_flag), 0);
      for (int w = 0; w < 6; w++) rx_cyc(1'b1, word_of(w), 1'b0, 1'b0);
      chk("R5 no lock unaligned", 32'(locked), 0);
      for (int w = 0; w < 4; w++) begin
        rx_cyc(1'b1, word_of(w), 1'b1, 1'b0);
        if (sl == 0 && w < 3) begin
          rx_cyc(1'b0, '0, 1'b1, 1'b0);
          chk("R6 idle adds nothing", 32'(locked), 0);
        end
        chk("R6 lock timing", 32'(locked), (w == 3) ? 1 : 0);
      end
      exp_n = hit_words(sl, 99);
      for (int w = 4; w < 16; w++) begin
        d = word_of(w);
        if (w == 6) d[DW-1-(99 % DW)] = ~d[DW-1-(99 % DW)];
        rx_cyc(1'b1, d, 1'b1, 1'b0);
        if (w == 5) chk("R7 clean words", 32'(err_cnt), 0);
      end
      chk("R7 flipped bit count", 32'(err_cnt), 32'(exp_n));
      chk("R9 flag set", 32'(err_flag), 1);
      poly_sel = 2'((sl + 1) % 4);
      rx_cyc(1'b1, ~word_of(16), 1'b1, 1'b0);
      chk("R10 select change drops lock", 32'(locked), 0);
      chk("R10 restart word not counted", 32'(err_cnt), 32'(exp_n));
    end

    // Alignment loss and relock with gaps (R10, R6)
    poly_sel = 2'd1; build_seq(1, 23'h0ACE);
    rx_cyc(1'b0, '0, 1'b0, 1'b1);
    lock_up(0);
    chk("R6 locked", 32'(locked), 1);
    rx_cyc(1'b1, word_of(4), 1'b0, 1'b0);
    chk("R10 align loss drops lock", 32'(locked), 0);
    for (int w = 5; w < 9; w++) begin
      rx_cyc(1'b1, word_of(w), 1'b1, 1'b0);
      chk("R10 relock count restarted", 32'(locked), (w == 8) ? 1 : 0);
      rx_cyc(1'b0, '0, 1'b1, 1'b0);
    end
    rx_cyc(1'b1, word_of(9), 1'b1, 1'b0);
    chk("R7 history kept across restart", 32'(err_cnt), 0);

    // Clear and error on the same edge (R9)
    poly_sel = 2'd3; build_seq(3, 23'h5F0F1);
    rx_cyc(1'b0, '0, 1'b0, 1'b1);
    lock_up(0);
    begin
      logic [DW-1:0] d;
      d = word_of(4); d[DW-1] = ~d[DW-1];
      rx_cyc(1'b1, d, 1'b1, 1'b0);
      chk("R7 p23 first hit", 32'(err_cnt), 1);
      rx_cyc(1'b1, word_of(5), 1'b1, 1'b0);
      chk("R7 p23 echo word", 32'(err_cnt), 2);
      rx_cyc(1'b1, word_of(6), 1'b1, 1'b0);
      chk("R7 p23 quiet", 32'(err_cnt), 2);
      d = word_of(7); d[0] = ~d[0];
      rx_cyc(1'b1, d, 1'b1, 1'b1);
      chk("R9 clear with hit count", 32'(err_cnt), 1);
      chk("R9 clear with hit flag", 32'(err_flag), 1);
      rx_cyc(1'b1, word_of(8), 1'b1, 1'b0);
      chk("R7 p23 gap word", 32'(err_cnt), 1);
      rx_cyc(1'b1, word_of(9), 1'b1, 1'b0);
      chk("R7 p23 delayed echo", 32'(err_cnt), 2);
    end

    // Saturation (R8)
    poly_sel = 2'd0; build_seq(0, 23'h55);
    rx_cyc(1'b0, '0, 1'b0, 1'b1);
    lock_up(0);
    for (int w = 4; w < 24; w++) begin
      logic [DW-1:0] d;
      d = word_of(w); d[DW-1] = ~d[DW-1];
      rx_cyc(1'b1, d, 1'b1, 1'b0);
      if (w == 10) chk("R8 counting", 32'(err_cnt), 7);
      if (w == 18) chk("R8 reaches max", 32'(err_cnt), 15);
    end
    chk("R8 holds at max", 32'(err_cnt), 15);
    chk("R9 flag after saturation", 32'(err_flag), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule